// File: doc/BRIEF.md
# Pipelined Single-Precision Adder-Subtractor

This block adds or subtracts two single-precision binary floating-point words. One operand pair is accepted on any cycle in which `in_valid` is high, and the answer comes out exactly 16 cycles later with `out_valid`. A `sub_mode` input picks the operation for each pair, so add and subtract requests can be mixed freely in the stream. Finite results are rounded to nearest, with ties going to the even mantissa.

The special cases follow a fixed, non-standard policy. Every NaN result is returned as one positive quiet NaN word. Both exponent overflow and underflow return a single positive signalling-NaN pattern and raise two flags. Operands with an all-zero exponent field are read as zero, so subnormal values are not supported. Six flag outputs are registered together with the result and are qualified by `out_valid`.

Top module: `fpas_top`

## Requirements
- R1: A pair accepted while `in_valid` is high produces `out_valid` high exactly 16 rising edges later. A new pair can be accepted on every cycle, and `out_valid` is never high unless a pair is due.
- R2: Finite results are rounded to nearest with ties to even. This includes a mantissa carry into the next exponent (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R3: An operand whose exponent field is 255 with a nonzero fraction is a NaN. If either operand is a NaN, the result is 0x7FC00000 with only `flag_qnan` set, and `flag_snan` stays low.
- R4: Zero combined with zero gives +0 (0x00000000) with all flags low. Zero combined with a finite y returns y with its effective sign, so zero minus a positive y gives -y. Exact cancellation of finite operands gives +0.
- R5: With `sub_mode`=0, +inf plus -inf gives 0x7FC00000 with `flag_qnan`, and two infinities of the same sign give that infinity.
- R6: With `sub_mode`=1, +inf minus +inf and -inf minus -inf give 0x7FC00000 with `flag_qnan`. +inf minus -inf gives +inf, and zero minus +inf gives -inf (0xFF800000) with `flag_ninf`.
- R7: If a finite result rounds to an exponent field of 255 or more, the output is 0x7FA00000 with `flag_ovf` and `flag_snan` high.
- R8: If a nonzero finite result falls below exponent field 1, the output is 0x7FA00000 with `flag_unf` and `flag_snan` high.
- R9: An infinite result (0x7F800000 or 0xFF800000) raises `flag_pinf` or `flag_ninf` to match its sign, and no other flag.
- R10: Reset is synchronous and active low. While `rst_n` is low and on the edge after, `out_valid` and all flags are low, and pairs in flight at reset never appear.
- R11: All six flags are low whenever `out_valid` is low. At most one of the quiet-NaN, signalling-NaN, positive-infinity and negative-infinity flags is high.
- R12: An operand with a zero exponent field counts as zero whatever its fraction holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair valid this cycle |
| sub_mode | input | 1 | 0: opa + opb, 1: opa - opb |
| opa | input | 32 | First operand, single precision |
| opb | input | 32 | Second operand, single precision |
| out_valid | output | 1 | Result and flags valid |
| sum_out | output | 32 | Result word |
| flag_ovf | output | 1 | Exponent overflow |
| flag_unf | output | 1 | Exponent underflow |
| flag_snan | output | 1 | Signalling-NaN pattern returned |
| flag_qnan | output | 1 | Quiet NaN returned |
| flag_pinf | output | 1 | Positive infinity returned |
| flag_ninf | output | 1 | Negative infinity returned |

## Verification
The assertions check several properties on every cycle. Each output word must match the flags raised with it: the quiet-NaN word, the signalling-NaN pattern, and the two infinities. Flags must be quiet when `out_valid` is low, the NaN and infinity flags must be mutually exclusive, an output must never appear without a pair in flight, and internal ordering must hold, namely that the larger operand is placed first and the rounded mantissa stays normalized. Only the bench scenarios can show that the numeric value is correctly rounded, that the exact 16-cycle spacing and back-to-back throughput hold, that each special-operand combination gives the right value in each mode, and that a reset in mid-stream discards pairs in flight.

// File: rtl/fpas_pkg.sv
// Shared widths, constant words and stage records for the single-precision
// adder-subtractor. Assumes the standard 1/8/23 binary32 field split.
package fpas_pkg;

    localparam int unsigned EXP_W  = 8;
    localparam int unsigned FRAC_W = 23;
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
    localparam int unsigned MANT_W = FRAC_W + 1;
    localparam int unsigned GRS_W  = 3;
    localparam int unsigned ALN_W  = MANT_W + GRS_W;
    localparam int unsigned SUM_W  = ALN_W + 1;
    localparam int unsigned ESIG_W = EXP_W + 2;
    localparam int unsigned LZ_W   = $clog2(ALN_W);
    localparam int unsigned EXP_MAX = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] SNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 2'b01, {(FRAC_W-2){1'b0}}};
    localparam logic [WORD_W-1:0] PINF_WORD =
        {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-1:0] NINF_WORD =
        {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic ovf;
        logic unf;
        logic snan;
        logic qnan;
        logic pinf;
        logic ninf;
    } fpas_flags_t;

    localparam int unsigned FLAG_W = $bits(fpas_flags_t);

    typedef struct packed {
        logic               special;
        logic [WORD_W-1:0]  word;
        fpas_flags_t        flags;
        logic               sign;
        logic [EXP_W-1:0]   exp;
        logic [EXP_W-1:0]   diff;
        logic [MANT_W-1:0]  mx;
        logic [MANT_W-1:0]  my;
        logic               esub;
    } fpas_s1_t;

    typedef struct packed {
        logic               special;
        logic [WORD_W-1:0]  word;
        fpas_flags_t        flags;
        logic               sign;
        logic [EXP_W-1:0]   exp;
        logic [SUM_W-1:0]   sum;
    } fpas_s2_t;

endpackage

// File: rtl/fpas_classify.sv
// Stage 1: classifies both operands, resolves the special cases (NaN,
// infinity, zero) into a final word and flags, and orders the finite pair
// so that the larger magnitude comes first. Assumes exponent field zero
// means zero (no subnormals).
module fpas_classify
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              out_valid,
    output fpas_s1_t          out_s1
);

    logic              sa, sb, sbe;
    logic [EXP_W-1:0]  ea, eb;
    logic [FRAC_W-1:0] fa, fb;
    logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, swap;
    fpas_s1_t nxt;

    assign {sa, ea, fa} = a;
    assign {sb, eb, fb} = b;
    assign sbe    = sb ^ op_sub;
    assign a_nan  = (&ea) && (|fa);
    assign b_nan  = (&eb) && (|fb);
    assign a_inf  = (&ea) && !(|fa);
    assign b_inf  = (&eb) && !(|fb);
    assign a_zero = (ea == '0);
    assign b_zero = (eb == '0);
    assign swap   = ({eb, fb} > {ea, fa});

    // Build the stage record: ordered finite operands plus special override.
    always_comb begin
        nxt       = '0;
        nxt.sign  = swap ? sbe : sa;
        nxt.exp   = swap ? eb : ea;
        nxt.diff  = swap ? (eb - ea) : (ea - eb);
        nxt.mx    = swap ? {1'b1, fb} : {1'b1, fa};
        nxt.my    = swap ? {1'b1, fa} : {1'b1, fb};
        nxt.esub  = sa ^ sbe;
        if (a_nan || b_nan) begin
            nxt.special    = 1'b1;
            nxt.word       = QNAN_WORD;
            nxt.flags.qnan = 1'b1;
        end else if (a_inf && b_inf) begin
            nxt.special = 1'b1;
            if (sa == sbe) begin
                nxt.word       = sa ? NINF_WORD : PINF_WORD;
                nxt.flags.ninf = sa;
                nxt.flags.pinf = !sa;
            end else begin
                nxt.word       = QNAN_WORD;
                nxt.flags.qnan = 1'b1;
            end
        end else if (a_inf || b_inf) begin
            nxt.special    = 1'b1;
            nxt.word       = (a_inf ? sa : sbe) ? NINF_WORD : PINF_WORD;
            nxt.flags.ninf = a_inf ? sa : sbe;
            nxt.flags.pinf = a_inf ? !sa : !sbe;
        end else if (a_zero && b_zero) begin
            nxt.special = 1'b1;
            nxt.word    = '0;
        end else if (a_zero) begin
            nxt.special = 1'b1;
            nxt.word    = {sbe, eb, fb};
        end else if (b_zero) begin
            nxt.special = 1'b1;
            nxt.word    = a;
        end
    end

    // Stage register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_s1    <= '0;
        end else begin
            out_valid <= in_valid;
            out_s1    <= nxt;
        end
    end

    a_r3_nan_input_gives_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_nan || b_nan)) |=>
        (out_s1.special && out_s1.flags.qnan && !out_s1.flags.snan));

endmodule

// File: rtl/fpas_align_add.sv
// Stage 2: shifts the smaller mantissa right by the exponent difference,
// keeping guard, round and sticky bits, then adds or subtracts. Assumes
// stage 1 placed the larger magnitude first, so the difference is never negative.
module fpas_align_add
    import fpas_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  fpas_s1_t in_s1,
    output logic     out_valid,
    output fpas_s2_t out_s2
);

    localparam logic [EXP_W-1:0] SHIFT_LIM = EXP_W'(ALN_W);

    logic [ALN_W-1:0] ext_x, ext_y, shifted, mask, aligned;
    logic             sticky;
    logic [SUM_W-1:0] sum;

    // Alignment shifter with sticky collection.
    always_comb begin
        ext_x   = {in_s1.mx, {GRS_W{1'b0}}};
        ext_y   = {in_s1.my, {GRS_W{1'b0}}};
        shifted = ext_y >> in_s1.diff;
        mask    = ~({ALN_W{1'b1}} << in_s1.diff);
        sticky  = |(ext_y & mask);
        if (in_s1.diff >= SHIFT_LIM) begin
            aligned = {{(ALN_W-1){1'b0}}, 1'b1};
        end else begin
            aligned = shifted | {{(ALN_W-1){1'b0}}, sticky};
        end
    end

    // Magnitude add or subtract.
    always_comb begin
        if (in_s1.esub) sum = {1'b0, ext_x} - {1'b0, aligned};
        else            sum = {1'b0, ext_x} + {1'b0, aligned};
    end

    // Stage register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_s2    <= '0;
        end else begin
            out_valid       <= in_valid;
            out_s2.special  <= in_s1.special;
            out_s2.word     <= in_s1.word;
            out_s2.flags    <= in_s1.flags;
            out_s2.sign     <= in_s1.sign;
            out_s2.exp      <= in_s1.exp;
            out_s2.sum      <= sum;
        end
    end

    a_r2_larger_first: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_s1.special && in_s1.diff == '0) |-> (in_s1.mx >= in_s1.my));

endmodule

// File: rtl/fpas_norm_round.sv
// Stage 3: normalizes the raw sum with a leading-zero count, rounds to
// nearest with ties to even, detects exponent overflow and underflow, and
// chooses the final word and flags. Flags leave this stage gated by valid.
module fpas_norm_round
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  fpas_s2_t          in_s2,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output fpas_flags_t       out_flags
);

    localparam logic signed [ESIG_W-1:0] E_TOP  = ESIG_W'(EXP_MAX);
    localparam logic signed [ESIG_W-1:0] E_ZERO = '0;
    localparam logic signed [ESIG_W-1:0] E_ONE  = ESIG_W'(1);

    logic [LZ_W-1:0]          lz;
    logic                     found;
    logic [ALN_W-1:0]         nrm;
    logic signed [ESIG_W-1:0] e_base, e_pre, e_fin;
    logic                     up;
    logic [MANT_W:0]          mr;
    logic [WORD_W-1:0]        word_n;
    fpas_flags_t              flags_n;

    // Leading-zero count over the in-range part of the sum.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = ALN_W - 1; i >= 0; i--) begin
            if (!found && in_s2.sum[i]) begin
                lz    = LZ_W'(ALN_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    // Normalize, round and adjust the exponent.
    always_comb begin
        e_base = signed'({2'b00, in_s2.exp});
        if (in_s2.sum[SUM_W-1]) begin
            nrm   = {in_s2.sum[SUM_W-1:2], |in_s2.sum[1:0]};
            e_pre = e_base + E_ONE;
        end else begin
            nrm   = in_s2.sum[ALN_W-1:0] << lz;
            e_pre = e_base - signed'({{(ESIG_W-LZ_W){1'b0}}, lz});
        end
        up    = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
        mr    = {1'b0, nrm[ALN_W-1:GRS_W]} + {{MANT_W{1'b0}}, up};
        e_fin = e_pre + signed'({{(ESIG_W-1){1'b0}}, mr[MANT_W]});
    end

    // Final word and flag selection.
    always_comb begin
        flags_n = '0;
        if (in_s2.special) begin
            word_n  = in_s2.word;
            flags_n = in_s2.flags;
        end else if (in_s2.sum == '0) begin
            word_n = '0;
        end else if (e_fin >= E_TOP) begin
            word_n       = SNAN_WORD;
            flags_n.ovf  = 1'b1;
            flags_n.snan = 1'b1;
        end else if (e_fin <= E_ZERO) begin
            word_n       = SNAN_WORD;
            flags_n.unf  = 1'b1;
            flags_n.snan = 1'b1;
        end else begin
            word_n = {in_s2.sign, e_fin[EXP_W-1:0], mr[FRAC_W-1:0]};
        end
    end

    // Stage register; flags only leave with a valid result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            out_word  <= word_n;
            out_flags <= in_valid ? flags_n : '0;
        end
    end

    a_r2_rounded_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_s2.special && in_s2.sum != '0) |-> (mr[MANT_W] | mr[MANT_W-1]));

endmodule

// File: rtl/fpas_delay.sv
// Plain register chain that pads the pipeline to the required latency.
// Assumes DEPTH may be zero, in which case it is a wire.
module fpas_delay #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] taps [DEPTH];
            // Shift one place per cycle, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= din;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
            assign dout = taps[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/fpas_top.sv
// Single-precision adder-subtractor with a fixed latency: three compute
// stages followed by a padding chain. Accepts one pair per cycle.
// Assumes LATENCY >= 3 and normalized or zero operands.
module fpas_top
    import fpas_pkg::*;
#(
    parameter int unsigned LATENCY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sub_mode,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_valid,
    output logic [WORD_W-1:0] sum_out,
    output logic              flag_ovf,
    output logic              flag_unf,
    output logic              flag_snan,
    output logic              flag_qnan,
    output logic              flag_pinf,
    output logic              flag_ninf
);

    localparam int unsigned COMPUTE_STAGES = 3;
    localparam int unsigned PAD_DEPTH = LATENCY - COMPUTE_STAGES;
    localparam int unsigned PAY_W = 1 + FLAG_W + WORD_W;
    localparam int unsigned CNT_W = $clog2(LATENCY + 1) + 1;

    logic              v1, v2, v3;
    fpas_s1_t          s1;
    fpas_s2_t          s2;
    logic [WORD_W-1:0] w3;
    fpas_flags_t       f3, f_out;
    logic [PAY_W-1:0]  pay_out;

    fpas_classify u_classify (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(sub_mode),
        .a(opa), .b(opb), .out_valid(v1), .out_s1(s1)
    );

    fpas_align_add u_align_add (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_s1(s1),
        .out_valid(v2), .out_s2(s2)
    );

    fpas_norm_round u_norm_round (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_s2(s2),
        .out_valid(v3), .out_word(w3), .out_flags(f3)
    );

    fpas_delay #(.WIDTH(PAY_W), .DEPTH(PAD_DEPTH)) u_pad (
        .clk(clk), .rst_n(rst_n), .din({v3, f3, w3}), .dout(pay_out)
    );

    assign {out_valid, f_out, sum_out} = pay_out;
    assign flag_ovf  = f_out.ovf;
    assign flag_unf  = f_out.unf;
    assign flag_snan = f_out.snan;
    assign flag_qnan = f_out.qnan;
    assign flag_pinf = f_out.pinf;
    assign flag_ninf = f_out.ninf;

    // Pairs in flight, for checking only.
    logic [CNT_W-1:0] inflight;
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    a_r1_no_orphan_output: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));
    a_r1_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(LATENCY));
    a_r11_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (f_out == '0));
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_qnan, flag_snan, flag_pinf, flag_ninf}));
    a_r3_qnan_word: assert property (@(posedge clk) disable iff (!rst_n)
        flag_qnan |-> (sum_out == QNAN_WORD && !flag_snan));
    a_r7_overflow_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf |-> (sum_out == SNAN_WORD && flag_snan && !flag_unf));
    a_r8_underflow_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        flag_unf |-> (sum_out == SNAN_WORD && flag_snan && !flag_ovf));
    a_r9_pinf_word: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pinf |-> (sum_out == PINF_WORD));
    a_r9_ninf_word: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ninf |-> (sum_out == NINF_WORD));
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && f_out == '0));

endmodule

// File: tb/test_fpas_top.sv
// Bench: directed corner cases plus seeded random pairs, checked against an
// exact-integer reference model computed here.
module test_fpas_top;

    localparam int LAT = 16;
    localparam logic [31:0] QN = 32'h7FC0_0000;
    localparam logic [31:0] SN = 32'h7FA0_0000;
    localparam logic [5:0] F_NONE = 6'b000000;
    localparam logic [5:0] F_OVF  = 6'b101000;
    localparam logic [5:0] F_UNF  = 6'b011000;
    localparam logic [5:0] F_QNAN = 6'b000100;
    localparam logic [5:0] F_PINF = 6'b000010;
    localparam logic [5:0] F_NINF = 6'b000001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic sub_mode = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic out_valid;
    logic [31:0] sum_out;
    logic flag_ovf, flag_unf, flag_snan, flag_qnan, flag_pinf, flag_ninf;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int          q_cyc[$];
    logic [37:0] q_exp[$];
    string       q_tag[$];

    fpas_top i_fpas_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_mode(sub_mode),
        .opa(opa), .opb(opb), .out_valid(out_valid), .sum_out(sum_out),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_snan(flag_snan),
        .flag_qnan(flag_qnan), .flag_pinf(flag_pinf), .flag_ninf(flag_ninf)
    );

    always #4 clk = ~clk;

    function automatic logic [37:0] inf_of(input logic s);
        return {s ? F_NINF : F_PINF, s, 8'hFF, 23'h0};
    endfunction

    // Reference: {flags(ovf,unf,snan,qnan,pinf,ninf), word}
    function automatic logic [37:0] model(input logic [31:0] a, input logic [31:0] b, input logic sub);
        logic sbe;
        logic [7:0] ea, eb;
        logic [22:0] fa, fb;
        logic [281:0] ma, mb, mag, rem, half;
        logic sg, up;
        logic [23:0] mant;
        logic [24:0] m25;
        int p, sh, e;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        sbe = b[31] ^ sub;
        if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0)) return {F_QNAN, QN};
        if (ea == 8'hFF && eb == 8'hFF) return (a[31] == sbe) ? inf_of(sbe) : {F_QNAN, QN};
        if (ea == 8'hFF) return inf_of(a[31]);
        if (eb == 8'hFF) return inf_of(sbe);
        if (ea == 0 && eb == 0) return {F_NONE, 32'h0};
        if (ea == 0) return {F_NONE, sbe, b[30:0]};
        if (eb == 0) return {F_NONE, a};
        ma = 282'({1'b1, fa}) << (ea - 1);
        mb = 282'({1'b1, fb}) << (eb - 1);
        if (a[31] == sbe) begin mag = ma + mb; sg = a[31]; end
        else if (ma >= mb) begin mag = ma - mb; sg = a[31]; end
        else begin mag = mb - ma; sg = sbe; end
        if (mag == 0) return {F_NONE, 32'h0};
        p = 0;
        for (int i = 281; i >= 0; i--) if (mag[i] && p == 0) p = i;
        if (p < 23) return {F_UNF, SN};
        sh = p - 23;
        mant = 24'(mag >> sh);
        rem = mag & ((282'd1 << sh) - 282'd1);
        half = (sh == 0) ? 282'd0 : (282'd1 << (sh - 1));
        up = (sh > 0) && ((rem > half) || (rem == half && mant[0]));
        m25 = {1'b0, mant} + 25'(up);
        e = p - 22 + (m25[24] ? 1 : 0);
        if (e >= 255) return {F_OVF, SN};
        if (e <= 0) return {F_UNF, SN};
        return {F_NONE, sg, 8'(e), m25[22:0]};
    endfunction

    task automatic chk(input string tag, input logic [38:0] act, input logic [38:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one cycle, check outputs at the falling edge, default inputs idle.
    task automatic step();
        logic [38:0] act;
        @(negedge clk);
        cyc++;
        act = {out_valid, flag_ovf, flag_unf, flag_snan, flag_qnan, flag_pinf, flag_ninf, sum_out};
        if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
            chk(q_tag[0], act, {1'b1, q_exp[0]});
            void'(q_cyc.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
        end else begin
            chk("R1/R11 idle", {out_valid, act[37:32]}, 7'b0);
        end
        in_valid = 1'b0;
    endtask

    task automatic send(input logic [31:0] x, input logic [31:0] y, input logic s,
                        input logic [37:0] e, input string tag);
        step();
        in_valid = 1'b1; opa = x; opb = y; sub_mode = s;
        q_cyc.push_back(cyc + LAT); q_exp.push_back(e); q_tag.push_back(tag);
    endtask

    function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
        return {s, 8'(e), f};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] x, y;
        logic s;
        int ea, eb, kind;
        void'($urandom(32'd20240611));
        repeat (3) step();
        chk("R10 reset state", {out_valid, flag_ovf, flag_unf, flag_snan, flag_qnan, flag_pinf, flag_ninf, sum_out}, 39'h0);
        rst_n = 1'b1;
        step();

        // R4 zeros and cancellation
        send(32'h0000_0000, 32'h0000_0000, 1'b0, {F_NONE, 32'h0}, "R4 zero plus zero");
        send(32'h0000_0000, 32'h4040_0000, 1'b1, {F_NONE, 32'hC040_0000}, "R4 zero minus y");
        send(32'h4040_0000, 32'h4040_0000, 1'b1, {F_NONE, 32'h0}, "R4 cancellation");
        // R3 NaN operands
        send(32'h7FA0_0001, 32'h3F80_0000, 1'b0, {F_QNAN, QN}, "R3 signalling in");
        send(32'h3F80_0000, 32'hFFC0_0000, 1'b1, {F_QNAN, QN}, "R3 quiet in");
        // R5 add-mode infinities
        send(32'h7F80_0000, 32'hFF80_0000, 1'b0, {F_QNAN, QN}, "R5 inf plus -inf");
        send(32'h7F80_0000, 32'h7F80_0000, 1'b0, {F_PINF, 32'h7F80_0000}, "R5 inf plus inf");
        // R6 subtract-mode infinities
        send(32'h7F80_0000, 32'h7F80_0000, 1'b1, {F_QNAN, QN}, "R6 inf minus inf");
        send(32'hFF80_0000, 32'hFF80_0000, 1'b1, {F_QNAN, QN}, "R6 -inf minus -inf");
        send(32'h7F80_0000, 32'hFF80_0000, 1'b1, {F_PINF, 32'h7F80_0000}, "R6 inf minus -inf");
        send(32'h0000_0000, 32'h7F80_0000, 1'b1, {F_NINF, 32'hFF80_0000}, "R6 zero minus inf");
        // R9 negative infinity result
        send(32'hFF80_0000, 32'h3F80_0000, 1'b0, {F_NINF, 32'hFF80_0000}, "R9 -inf plus finite");
        // R7 / R8 range limits
        send(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, {F_OVF, SN}, "R7 overflow");
        send(32'h0080_0001, 32'h0080_0000, 1'b1, {F_UNF, SN}, "R8 underflow");
        send(32'h00C0_0000, 32'h0080_0000, 1'b1, {F_UNF, SN}, "R8 underflow half");
        // R2 rounding
        send(32'h3F80_0000, 32'h3380_0000, 1'b0, {F_NONE, 32'h3F80_0000}, "R2 tie to even low");
        send(32'h3F80_0001, 32'h3380_0000, 1'b0, {F_NONE, 32'h3F80_0002}, "R2 tie to even up");
        send(32'h3F80_0000, 32'h3380_0001, 1'b0, {F_NONE, 32'h3F80_0001}, "R2 above half");
        send(32'h3FFF_FFFF, 32'h3380_0000, 1'b0, {F_NONE, 32'h4000_0000}, "R2 carry to exponent");
        send(32'h3FC0_0000, 32'h3FC0_0000, 1'b0, {F_NONE, 32'h4040_0000}, "R2 sum carry");
        // R12 zero exponent field
        send(32'h0012_3456, 32'h3F80_0000, 1'b0, {F_NONE, 32'h3F80_0000}, "R12 flushed operand");

        // R1 random stream with gaps and back-to-back pairs
        for (int n = 0; n < 3000; n++) begin
            kind = $urandom_range(0, 99);
            s = 1'($urandom_range(0, 1));
            ea = $urandom_range(60, 190);
            eb = ea + $urandom_range(0, 60) - 30;
            x = mk(1'($urandom_range(0, 1)), ea, 23'($urandom()));
            y = mk(1'($urandom_range(0, 1)), eb, 23'($urandom()));
            if (kind >= 70 && kind < 80) begin
                y = {x[31] ^ ~s, x[30:3], x[2:0] ^ 3'($urandom_range(0, 7))};
            end else if (kind >= 80 && kind < 88) begin
                x = mk(1'b0, $urandom_range(250, 254), 23'($urandom()));
                y = mk(s, $urandom_range(250, 254), 23'($urandom()));
            end else if (kind >= 88 && kind < 94) begin
                x = mk(1'b0, $urandom_range(1, 3), 23'($urandom()));
                y = mk(~s, $urandom_range(1, 3), 23'($urandom()));
            end else if (kind >= 94) begin
                case ($urandom_range(0, 4))
                    0: y = 32'h0000_0000;
                    1: y = 32'h7F80_0000;
                    2: y = 32'hFF80_0000;
                    3: y = 32'h7FC0_0001;
                    default: y = 32'h0000_1234;
                endcase
            end
            if ($urandom_range(0, 4) == 0) step();
            send(x, y, s, model(x, y, s), "R2 random");
        end
        repeat (LAT + 2) step();

        // R10 reset in mid-stream discards pairs in flight
        for (int n = 0; n < 5; n++) send(32'h3F80_0000, 32'h4000_0000, 1'b0, {F_NONE, 32'h4040_0000}, "R10 pre");
        step();
        rst_n = 1'b0;
        q_cyc.delete(); q_exp.delete(); q_tag.delete();
        step();
        chk("R10 held", {out_valid, flag_ovf, flag_unf, flag_snan, flag_qnan, flag_pinf, flag_ninf, sum_out}, 39'h0);
        step();
        rst_n = 1'b1;
        repeat (LAT + 4) step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule